// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block sits in a host bridge and turns up to eight level-sensitive interrupt lines from the PCI side into message writes aimed at a CPU interrupt register. Each line owns two words in an indirectly addressed redirection table. The control word holds a mask bit, trigger and polarity flags and a 6-bit vector. The destination word holds a CPU address in a swizzled form. Software reaches the table through a select register and a data window on a 64-bit register bus that also accepts 32-bit half accesses. A separate end-of-interrupt register clears the pending state of every line whose vector matches the value written.

The block watches each line for level changes and handles at most one changed line per clock, lowest index first. When an unmasked line with a non-zero destination word rises, the block sets a pending bit. That bit is chosen by the low bits of the vector, not by the line number. If the bit was clear before, one 32-bit write carrying the vector goes into a small queue feeding a valid/ready message port. While the queue is full, level changes wait. None are dropped.

Top module: `irq_redirect`

## Requirements
- R1: After reset the pending bits are zero, the select register reads 0 and no message is offered. For line i the control word (table index 0x10+2i) reads 0x1A000 + (i+2): masked, level, active-low, vector i+2. The destination word (index 0x11+2i) reads the swizzled CPU_ADDR, ((a&0x0ff00000)>>4)|((a&0x000ff000)<<12), which is 0xA0FF0000 for the default 0xFFFA0000. All other table words read 0.
- R2: The select register sits at byte offset 0x800 and the data window at 0x810. A window write stores 32 bits into table[select]. A 64-bit window read returns that word zero-extended.
- R3: A window read with select = 1 returns the version word (TABLE_WORDS<<16)|1, which is 0x00200001 by default, whatever table word 1 holds.
- R4: A 64-bit write takes data bits 31:0. A 32-bit access with address bit 2 set uses the upper lane: a write takes data bits 63:32, and a read returns the upper half of the 64-bit register value in bits 31:0. A 32-bit access with address bit 2 clear uses the lower lane.
- R5: A rising line i whose control bit 16 is clear and whose destination word is non-zero sets pending bit (vector mod 8). If that bit was clear, exactly one message is sent. Its address is 0xFFFFFFFF in bits 63:32 and ((d<<4)&0x0ff00000)|((d>>12)&0x000ff000)|0xF0000000 in bits 31:0. Its data carries the vector big-endian, in bits 29:24.
- R6: A falling line, or a rising line that is masked or has a zero destination word, clears pending bit (vector mod 8) and sends no message.
- R7: A qualifying rise whose pending bit is already set sends no message.
- R8: A write to the end-of-interrupt register at 0x840 takes data bits 5:0. For every line i whose vector equals that value, it clears pending bit i (the line index, not the vector index).
- R9: A message stays offered, with stable address and data, until msgReady is seen. Up to two messages queue. Beyond that, level changes are held back and are later served lowest line first, so none is lost.
- R10: Any access to an undecoded offset, any window access with select >= TABLE_WORDS, and any read of the end-of-interrupt register is a miss. With hardFailEn low, a miss reads all ones, ignores the write and reports no error. With hardFailEn high, a miss reports an error and reads 0.
- R11: Every register request gets exactly one response, on the clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hardFailEn | input | 1 | Report misses as errors |
| regValid | input | 1 | Register request strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regSize64 | input | 1 | 1 = 64-bit access, 0 = 32-bit half |
| regAddr | input | ADDR_W-2 | Byte address bits ADDR_W-1:2 |
| regWdata | input | 64 | Write data, both lanes |
| rspValid | output | 1 | Response strobe |
| rspData | output | 64 | Read data |
| rspErr | output | 1 | Decode error |
| irqIn | input | NUM_LINES | Level interrupt lines |
| msgValid | output | 1 | Message offered |
| msgReady | input | 1 | Message accepted |
| msgAddr | output | 64 | Message destination address |
| msgData | output | 32 | Message data (vector, big-endian) |

## Verification
The bench builds the block with the default parameters: eight lines, a 32-word table, a two-entry message queue and CPU_ADDR 0xFFFA0000. Eight lines are enough to give pairs of lines whose vectors differ but share a pending bit. That makes the shared-bit suppression and the line-indexed end-of-interrupt clear observable as present or missing messages. A queue depth of two means that four lines rising together with msgReady held low exercise both the queue and the held-back path, and the arrival order shows the lowest-first service.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  typedef struct packed {
    logic        tblWr;
    logic        eoiWr;
    logic [5:0]  eoiVec;
    logic [31:0] wrData;
  } dpStrobe_t;

  function automatic logic [31:0] swizzleDest(input logic [31:0] a);
    return ((a & 32'h0ff00000) >> 4) | ((a & 32'h000ff000) << 12);
  endfunction

  function automatic logic [31:0] unswizzleDest(input logic [31:0] d);
    return ((d << 4) & 32'h0ff00000) | ((d >> 12) & 32'h000ff000) | 32'hf0000000;
  endfunction

endpackage

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int TABLE_WORDS = 32,
  parameter int SEL_OFF     = 'h800,
  parameter int WIN_OFF     = 'h810,
  parameter int EOI_OFF     = 'h840,
  localparam int IDX_W      = $clog2(TABLE_WORDS),
  localparam int WA_W       = ADDR_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hardFailEn,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic              regSize64,
  input  logic [ADDR_W-1:2] regAddr,
  input  logic [63:0]       regWdata,
  input  logic [31:0]       tblWord,
  output logic [IDX_W-1:0]  selIdx,
  output dpStrobe_t         strb,
  output logic              rspValid,
  output logic [63:0]       rspData,
  output logic              rspErr
);

  localparam logic [WA_W-1:0] WA_SEL = WA_W'(SEL_OFF >> 3);
  localparam logic [WA_W-1:0] WA_WIN = WA_W'(WIN_OFF >> 3);
  localparam logic [WA_W-1:0] WA_EOI = WA_W'(EOI_OFF >> 3);
  localparam logic [31:0] VERSION_WORD = (32'(TABLE_WORDS) << 16) | 32'd1;

  logic [31:0] selReg;
  logic [31:0] lane;
  logic [63:0] fullVal;
  logic [63:0] rdOut;
  logic        miss;
  logic        isSel, isWin, isEoi, selInRange;

  always_comb begin
    lane       = (regSize64 || !regAddr[2]) ? regWdata[31:0] : regWdata[63:32];
    isSel      = regAddr[ADDR_W-1:3] == WA_SEL;
    isWin      = regAddr[ADDR_W-1:3] == WA_WIN;
    isEoi      = regAddr[ADDR_W-1:3] == WA_EOI;
    selInRange = selReg < 32'(TABLE_WORDS);
    fullVal    = '0;
    miss       = 1'b0;
    if (isSel)                                  fullVal = {32'b0, selReg};
    else if (isWin && !regWrite && selReg == 1) fullVal = {32'b0, VERSION_WORD};
    else if (isWin && selInRange)               fullVal = {32'b0, tblWord};
    else if (isEoi && regWrite)                 fullVal = '0;
    else                                        miss = 1'b1;
    if (miss) fullVal = hardFailEn ? 64'h0 : {64{1'b1}};
    if (regSize64)       rdOut = fullVal;
    else if (regAddr[2]) rdOut = {32'b0, fullVal[63:32]};
    else                 rdOut = {32'b0, fullVal[31:0]};
    strb.tblWr  = regValid && regWrite && isWin && selInRange;
    strb.eoiWr  = regValid && regWrite && isEoi;
    strb.eoiVec = lane[5:0];
    strb.wrData = lane;
  end

  assign selIdx = selReg[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      selReg   <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
      rspErr   <= 1'b0;
    end else begin
      if (regValid && regWrite && isSel) selReg <= lane;
      rspValid <= regValid;
      rspData  <= (regValid && !regWrite) ? rdOut : '0;
      rspErr   <= regValid && miss && hardFailEn;
    end
  end

  AST_ERR_NEEDS_HARDFAIL: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspErr) |-> $past(hardFailEn)); // R10

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    regValid |=> rspValid); // R11

endmodule

// File: rtl/irq_redir_dp.sv
module irq_redir_dp
  import irq_redir_pkg::*;
#(
  parameter int NUM_LINES       = 8,
  parameter int TABLE_WORDS     = 32,
  parameter int FIFO_DEPTH      = 2,
  parameter logic [31:0] CPU_ADDR = 32'hfffa0000,
  localparam int IDX_W          = $clog2(TABLE_WORDS),
  localparam int LINE_W         = $clog2(NUM_LINES),
  localparam int TBL_BASE       = 16,
  localparam int FP_W           = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int CNT_W          = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dpStrobe_t            strb,
  input  logic [IDX_W-1:0]     selIdx,
  output logic [31:0]          tblWord,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic                 msgValid,
  input  logic                 msgReady,
  output logic [63:0]          msgAddr,
  output logic [31:0]          msgData
);

  function automatic logic [31:0] resetWord(input int w);
    if (w >= TBL_BASE && w < TBL_BASE + 2 * NUM_LINES) begin
      if (((w - TBL_BASE) % 2) == 0) return 32'h0001a000 | 32'((w - TBL_BASE) / 2 + 2);
      else                           return swizzleDest(CPU_ADDR);
    end
    return 32'h0;
  endfunction

  logic [31:0]          tbl [TABLE_WORDS];
  logic [NUM_LINES-1:0] pending, pendBase, pendNext;
  logic [NUM_LINES-1:0] seenLvl, changed, eoiMask;
  logic [LINE_W-1:0]    pickIdx, pickBit;
  logic [31:0]          pickCtl, pickDst;
  logic                 found, go, live, push, pop, fifoFull;
  logic [31:0]          fAddr [FIFO_DEPTH];
  logic [5:0]           fVec  [FIFO_DEPTH];
  logic [FP_W-1:0]      wrPtr, rdPtr;
  logic [CNT_W-1:0]     count;

  assign tblWord = tbl[selIdx];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_eoi
    assign eoiMask[i] = tbl[IDX_W'(TBL_BASE + 2 * i)][5:0] == strb.eoiVec;
  end

  assign changed = irqIn ^ seenLvl;

  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (changed[i]) begin
        found   = 1'b1;
        pickIdx = LINE_W'(i);
      end
    end
    fifoFull = count == CNT_W'(FIFO_DEPTH);
    go       = found && !fifoFull;
    pickCtl  = tbl[IDX_W'(TBL_BASE + 2 * int'(pickIdx))];
    pickDst  = tbl[IDX_W'(TBL_BASE + 1 + 2 * int'(pickIdx))];
    pickBit  = pickCtl[LINE_W-1:0];
    live     = irqIn[pickIdx] && !pickCtl[16] && (pickDst != 32'h0);
    pendBase = pending & ~(strb.eoiWr ? eoiMask : '0);
    pendNext = pendBase;
    push     = 1'b0;
    if (go) begin
      pendNext[pickBit] = live;
      push = live && !pendBase[pickBit];
    end
  end

  assign pop      = msgValid && msgReady;
  assign msgValid = count != '0;
  assign msgAddr  = {32'hffffffff, fAddr[rdPtr]};
  assign msgData  = {2'b00, fVec[rdPtr], 24'h0};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < TABLE_WORDS; w++) tbl[w] <= resetWord(w);
      pending <= '0;
      seenLvl <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      for (int e = 0; e < FIFO_DEPTH; e++) begin
        fAddr[e] <= '0;
        fVec[e]  <= '0;
      end
    end else begin
      if (strb.tblWr) tbl[selIdx] <= strb.wrData;
      pending <= pendNext;
      if (go) seenLvl[pickIdx] <= irqIn[pickIdx];
      if (push) begin
        fAddr[wrPtr] <= unswizzleDest(pickDst);
        fVec[wrPtr]  <= pickCtl[5:0];
        wrPtr <= (wrPtr == FP_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (pop) rdPtr <= (rdPtr == FP_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  AST_MSG_HELD: assert property (@(posedge clk) disable iff (rst)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData))); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(FIFO_DEPTH)); // R9

  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (strb.eoiWr && !go) |=> ((pending & $past(eoiMask)) == '0)); // R8

  AST_SEND_SETS_PENDING: assert property (@(posedge clk) disable iff (rst)
    push |=> pending[$past(pickBit)]); // R5

endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
  import irq_redir_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter int ADDR_W     = 13,
  parameter int FIFO_DEPTH = 2,
  parameter logic [31:0] CPU_ADDR = 32'hfffa0000,
  localparam int TABLE_WORDS = 16 + 2 * NUM_LINES,
  localparam int IDX_W       = $clog2(TABLE_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hardFailEn,
  input  logic                 regValid,
  input  logic                 regWrite,
  input  logic                 regSize64,
  input  logic [ADDR_W-1:2]    regAddr,
  input  logic [63:0]          regWdata,
  output logic                 rspValid,
  output logic [63:0]          rspData,
  output logic                 rspErr,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic                 msgValid,
  input  logic                 msgReady,
  output logic [63:0]          msgAddr,
  output logic [31:0]          msgData
);

  dpStrobe_t        strb;
  logic [IDX_W-1:0] selIdx;
  logic [31:0]      tblWord;

  irq_redir_ctrl #(.ADDR_W(ADDR_W), .TABLE_WORDS(TABLE_WORDS)) u_ctrl (
    .clk(clk), .rst(rst), .hardFailEn(hardFailEn),
    .regValid(regValid), .regWrite(regWrite), .regSize64(regSize64),
    .regAddr(regAddr), .regWdata(regWdata), .tblWord(tblWord),
    .selIdx(selIdx), .strb(strb),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr)
  );

  irq_redir_dp #(.NUM_LINES(NUM_LINES), .TABLE_WORDS(TABLE_WORDS),
                 .FIFO_DEPTH(FIFO_DEPTH), .CPU_ADDR(CPU_ADDR)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .selIdx(selIdx), .tblWord(tblWord),
    .irqIn(irqIn), .msgValid(msgValid), .msgReady(msgReady),
    .msgAddr(msgAddr), .msgData(msgData)
  );

endmodule

// File: tb/irq_redirect_bench.sv
module irq_redirect_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hardFailEn = 1'b0;
  logic        regValid = 1'b0, regWrite = 1'b0, regSize64 = 1'b1;
  logic [12:2] regAddr = '0;
  logic [63:0] regWdata = '0;
  logic        rspValid, rspErr;
  logic [63:0] rspData;
  logic [7:0]  irqIn = '0;
  logic        msgValid, msgReady = 1'b1;
  logic [63:0] msgAddr;
  logic [31:0] msgData;

  irq_redirect u_irq_redirect (
    .clk(clk), .rst(rst), .hardFailEn(hardFailEn),
    .regValid(regValid), .regWrite(regWrite), .regSize64(regSize64),
    .regAddr(regAddr), .regWdata(regWdata),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr),
    .irqIn(irqIn), .msgValid(msgValid), .msgReady(msgReady),
    .msgAddr(msgAddr), .msgData(msgData)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, msgCount = 0;
  bit done = 0;
  logic [95:0] expQ[$];
  string       tagQ[$];
  logic [63:0] rd;
  logic        er, lastRv;
  localparam logic [63:0] DEF_ADDR = 64'hffffffff_fffa0000;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // Monitor: every accepted message is compared against the scoreboard.
  always @(negedge clk) begin
    if (!rst && msgValid && msgReady) begin
      msgCount++;
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R6: unexpected message actual %h/%h expected none", msgAddr, msgData);
      end else begin
        logic [95:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if ({msgAddr, msgData} !== e) begin
          fails++;
          $display("FAIL %s: message actual %h expected %h", t, {msgAddr, msgData}, e);
        end
      end
    end
  end

  task automatic expectMsg(input string tag, input logic [63:0] a, input logic [5:0] v);
    expQ.push_back({a, 2'b00, v, 24'h0});
    tagQ.push_back(tag);
  endtask

  task automatic busOp(input bit wr, input logic [12:0] addr, input bit s64,
                       input logic [63:0] wd);
    @(negedge clk);
    regValid = 1; regWrite = wr; regAddr = addr[12:2]; regSize64 = s64; regWdata = wd;
    @(negedge clk);
    regValid = 0;
    rd = rspData; er = rspErr; lastRv = rspValid;
  endtask

  task automatic tblWrite(input logic [31:0] idx, input logic [31:0] val);
    busOp(1, 13'h800, 1, {32'h0, idx});
    busOp(1, 13'h810, 1, {32'h0, val});
  endtask

  task automatic tblRead(input logic [31:0] idx);
    busOp(1, 13'h800, 1, {32'h0, idx});
    busOp(0, 13'h810, 1, 64'h0);
  endtask

  task automatic setIrq(input int i, input logic v);
    @(negedge clk);
    irqIn[i] = v;
    repeat (8) @(negedge clk);
  endtask

  task automatic setReady(input logic v);
    @(posedge clk);
    #1 msgReady = v;
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < 200 && expQ.size() != 0; k++) @(negedge clk);
    chk(tag, 64'(expQ.size()), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset defaults
    chk("R1 msgValid", 64'(msgValid), 64'd0);
    busOp(0, 13'h800, 1, 0);
    chk("R1 select", rd, 64'd0);
    chk("R11 rspValid", 64'(lastRv), 64'd1);
    busOp(0, 13'h810, 1, 0);
    chk("R1 word0", rd, 64'd0);
    tblRead(32'h10); chk("R1 ctl0", rd, 64'h1a002);
    tblRead(32'h11); chk("R1 dst0", rd, 64'ha0ff0000);
    tblRead(32'h1e); chk("R1 ctl7", rd, 64'h1a009);

    // R3: version word
    tblRead(32'h01); chk("R3 version", rd, 64'h00200001);

    // R2: window write and read back
    tblWrite(32'h05, 32'h12345678);
    busOp(0, 13'h810, 1, 0); chk("R2 window", rd, 64'h12345678);

    // R4: 32-bit lanes
    busOp(1, 13'h814, 0, {32'hcafef00d, 32'h11111111});
    busOp(0, 13'h810, 0, 0); chk("R4 low lane read", rd, 64'hcafef00d);
    busOp(0, 13'h814, 0, 0); chk("R4 high lane read", rd, 64'h0);
    busOp(0, 13'h800, 0, 0); chk("R4 sel low lane", rd, 64'h5);

    // R5: basic message, default destination
    tblWrite(32'h10, 32'h0000a022);
    expectMsg("R5 line0", DEF_ADDR, 6'h22);
    setIrq(0, 1);
    drain("R5 line0 drained");
    setIrq(0, 0);
    // R6: fall clears pending, so the next rise sends again
    expectMsg("R6 line0 re-rise", DEF_ADDR, 6'h22);
    setIrq(0, 1);
    drain("R6 re-rise drained");
    setIrq(0, 0);
    // R5: programmed destination unswizzle
    tblWrite(32'h12, 32'h0000a007);
    tblWrite(32'h13, 32'h12345678);
    expectMsg("R5 line1 dest", 64'hffffffff_f3412000, 6'h07);
    setIrq(1, 1);
    drain("R5 line1 drained");
    setIrq(1, 0);

    // R6: masked line and zero destination send nothing
    base = msgCount;
    setIrq(2, 1);
    chk("R6 masked", 64'(msgCount - base), 64'd0);
    setIrq(2, 0);
    tblWrite(32'h16, 32'h0000a001);
    tblWrite(32'h17, 32'h0);
    setIrq(3, 1);
    chk("R6 zero dest", 64'(msgCount - base), 64'd0);
    setIrq(3, 0);

    // R7: shared pending bit suppresses second message
    tblWrite(32'h18, 32'h0000a00c);
    tblWrite(32'h1a, 32'h0000a014);
    expectMsg("R7 line4", DEF_ADDR, 6'h0c);
    setIrq(4, 1);
    drain("R7 line4 drained");
    base = msgCount;
    setIrq(5, 1);
    chk("R7 shared bit", 64'(msgCount - base), 64'd0);
    setIrq(5, 0);
    setIrq(4, 0);

    // R8: EOI clears the bit of the matching line
    expectMsg("R8 line4", DEF_ADDR, 6'h0c);
    setIrq(4, 1);
    drain("R8 line4 drained");
    busOp(1, 13'h840, 1, 64'h0c);
    chk("R8 eoi no err", 64'(er), 64'd0);
    expectMsg("R8 line5 after eoi", DEF_ADDR, 6'h14);
    setIrq(5, 1);
    drain("R8 line5 drained");
    setIrq(4, 0);
    setIrq(5, 0);
    // R8: EOI clears by line index, not by vector index
    tblWrite(32'h1c, 32'h0000a003);
    tblWrite(32'h1e, 32'h0000a00b);
    expectMsg("R8 line6", DEF_ADDR, 6'h03);
    setIrq(6, 1);
    drain("R8 line6 drained");
    busOp(1, 13'h840, 1, 64'h03);
    base = msgCount;
    setIrq(7, 1);
    chk("R8 line-indexed clear", 64'(msgCount - base), 64'd0);
    setIrq(6, 0);
    setIrq(7, 0);

    // R9: back-pressure, queueing and lowest-first order
    tblWrite(32'h14, 32'h0000a010);
    tblWrite(32'h17, 32'ha0ff0000);
    setReady(0);
    base = msgCount;
    expectMsg("R9 order 0", DEF_ADDR, 6'h22);
    expectMsg("R9 order 1", 64'hffffffff_f3412000, 6'h07);
    expectMsg("R9 order 2", DEF_ADDR, 6'h10);
    expectMsg("R9 order 3", DEF_ADDR, 6'h01);
    @(negedge clk);
    irqIn[3:0] = 4'hf;
    repeat (20) @(negedge clk);
    chk("R9 held valid", 64'(msgValid), 64'd1);
    chk("R9 held addr", msgAddr, DEF_ADDR);
    chk("R9 held data", 64'(msgData), 64'h22000000);
    setReady(1);
    drain("R9 all drained");
    chk("R9 count", 64'(msgCount - base), 64'd4);
    @(negedge clk);
    irqIn[3:0] = 4'h0;
    repeat (8) @(negedge clk);

    // R10: misses with hard-fail off
    busOp(0, 13'h818, 1, 0);
    chk("R10 undecoded read", rd, {64{1'b1}});
    chk("R10 undecoded no err", 64'(er), 64'd0);
    busOp(1, 13'h800, 1, 64'h20);
    busOp(0, 13'h810, 1, 0);
    chk("R10 out-of-range read", rd, {64{1'b1}});
    busOp(1, 13'h810, 1, 64'hdead);
    tblRead(32'h0);
    chk("R10 write ignored", rd, 64'd0);
    // R10: misses with hard-fail on
    @(negedge clk); hardFailEn = 1;
    busOp(0, 13'h818, 1, 0);
    chk("R10 hf read data", rd, 64'd0);
    chk("R10 hf read err", 64'(er), 64'd1);
    busOp(0, 13'h840, 1, 0);
    chk("R10 hf eoi read err", 64'(er), 64'd1);
    busOp(1, 13'h800, 1, 64'h20);
    chk("R10 hf select ok", 64'(er), 64'd0);
    busOp(1, 13'h810, 1, 64'h1);
    chk("R10 hf window write err", 64'(er), 64'd1);
    chk("R11 write response", 64'(lastRv), 64'd1);

    repeat (10) @(negedge clk);
    chk("R9 no stray expected", 64'(expQ.size()), 64'd0);
    finishRun();
  end

endmodule